// File: doc/BRIEF.md
# Exception Entry/Exit Sequencer

This block sequences the cycle-exact timing of a processor core's exception handling. When the interrupt arbiter presents a request, the sequencer saves an eight-word context frame below the current stack pointer. It then reads the handler address from a vector table whose base is programmable. Finally it pulses a handler-start strobe. When the running handler finishes, the block takes one of two paths. If the arbiter offers another request at that moment, the sequencer tail-chains to that handler: it fetches only the new vector and saves no frame again. Otherwise it reads the frame back, hands each word to the core and returns either to thread code or to the handler that was interrupted.

The sequencer has nine states: `ST_IDLE` (thread code), `ST_STACK` (eight frame writes), `ST_VEC` (vector read), `ST_START` (handler-start strobe), `ST_ACTIVE` (handler running), `ST_TCHAIN` (tail-chain lead-in), `ST_UNSTACK` (eight frame reads), `ST_RESTORE` (settling) and `ST_RET` (return strobe). The transitions are as follows:
- take: `ST_IDLE`/`ST_ACTIVE` to `ST_STACK`
- push-done: `ST_STACK` to `ST_VEC`
- fetched: `ST_VEC` to `ST_START`
- run: `ST_START` to `ST_ACTIVE`
- chain: `ST_ACTIVE` to `ST_TCHAIN`, then lead-in-done: `ST_TCHAIN` to `ST_VEC`
- finish: `ST_ACTIVE` to `ST_UNSTACK`
- pop-done: `ST_UNSTACK` to `ST_RESTORE`
- settle: `ST_RESTORE` to `ST_RET`
- resume: `ST_RET` to `ST_ACTIVE`
- to-thread: `ST_RET` to `ST_IDLE`

Exception number 0 denotes thread code. Memory is word-addressed through byte addresses, and a read returns its data one cycle after it is issued.

Top module: `exc_seq_top`

## Requirements
- R1: After reset the block is in thread code: `busy`, `hdl_start`, `exc_ret`, `mem_we` and `mem_re` are low, `cur_num` is 0 and `sp` equals `SP_RESET`.
- R2: A request is acknowledged (`take_ack` high in the same cycle) only in thread code or while a handler runs. If it is accepted in cycle c, `hdl_start` is high in exactly cycle c+12 and `busy` is high in cycles c+1 to c+11.
- R3: Entry writes exactly 8 words, one per cycle in cycles c+1 to c+8, to the frame at `sp`-32. Word i (i = 0..6) is `core_regs[32*i +: 32]`. Word 7 is the status word: bits [31:6] are `core_flags` and bits [5:0] are the exception number that was current before entry (0 from thread code).
- R4: `sp` stays a multiple of 4. It shows its old value minus 32 from cycle c+9 onward after an entry.
- R5: The handler address is the word read at `vtor` + 4 × exception number, and `hdl_addr` holds it while `hdl_start` is high.
- R6: If `hdl_done` and `chain_req` are both high in cycle d, `hdl_start` for `chain_num` is high in cycle d+6. During the switch no frame word is written and `sp` does not change.
- R7: If `hdl_done` is high and `chain_req` is low in cycle d, the 8 frame words are read at `sp` + 4i. Each word is delivered on `ctx_wr_en`/`ctx_wr_idx`/`ctx_wr_data`. `exc_ret` is high in cycle d+12, and `sp` has risen by 32 by then.
- R8: On return, `cur_num` takes the number held in bits [5:0] of the restored status word. If it is 0 the block is back in thread code, and a later `hdl_done` has no effect. Otherwise the interrupted handler resumes without a new `hdl_start`, and its own `hdl_done` unstacks again.
- R9: A request accepted while a handler runs (preemption) performs the full 12-cycle entry. The interrupted number is saved in the status word, and that handler resumes on return.
- R10: A request presented while `busy` is high, or during the `hdl_start` cycle, is not acknowledged. It is taken in the first cycle a handler runs.
- R11: `cur_num` changes to the new handler's number in the `hdl_start` cycle, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| take_req | input | 1 | Arbiter request to enter a handler |
| take_num | input | NUM_W | Exception number of the request |
| take_ack | output | 1 | Request accepted this cycle |
| hdl_done | input | 1 | Running handler has finished |
| chain_req | input | 1 | Pending request to tail-chain to, valid with hdl_done |
| chain_num | input | NUM_W | Exception number to tail-chain to |
| vtor | input | XLEN | Vector table base address |
| core_regs | input | 7*XLEN | Core registers saved as frame words 0..6 |
| core_flags | input | XLEN-NUM_W | Flag bits placed above the number in the status word |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | XLEN | Memory byte address |
| mem_wdata | output | XLEN | Memory write data |
| mem_rdata | input | XLEN | Memory read data, valid one cycle after mem_re |
| hdl_start | output | 1 | Handler start strobe |
| hdl_addr | output | XLEN | Handler address fetched from the table |
| exc_ret | output | 1 | Return completed strobe |
| busy | output | 1 | Stacking, tail-chaining or unstacking in progress |
| cur_num | output | NUM_W | Number of the running exception, 0 in thread code |
| sp | output | XLEN | Stack pointer |
| ctx_wr_en | output | 1 | Restored frame word valid |
| ctx_wr_idx | output | 3 | Index of the restored frame word |
| ctx_wr_data | output | XLEN | Restored frame word |

## Verification
Each result has a fixed delay after the cycle in which its stimulus is sampled:
- `hdl_start` comes 12 cycles after an accepted request and 6 cycles after a chaining completion.
- `exc_ret` comes 12 cycles after a plain completion.
- `take_ack` answers in the same cycle.

The bench drives inputs on falling edges and counts falling edges from the stimulus until the strobe appears, so that an early or late strobe both show up as a count mismatch. `sp`, `cur_num`, `hdl_addr` and the frame contents are read on that same strobe cycle. The bench compares them with values computed from its own nesting stack and its vector-table formula. Write and restore counts are taken as differences across the sequence, so that a stray or missing word is caught.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    localparam int FRAME_WORDS  = 8;
    localparam int WORD_BYTES   = 4;
    localparam int ENTRY_CYCLES = 12;
    localparam int CHAIN_CYCLES = 6;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_STACK,
        ST_VEC,
        ST_START,
        ST_ACTIVE,
        ST_TCHAIN,
        ST_UNSTACK,
        ST_RESTORE,
        ST_RET
    } seq_state_e;

endpackage

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
    import exc_seq_pkg::*;
#(
    parameter int NUM_W = 6,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_req,
    input  logic [NUM_W-1:0] take_num,
    input  logic             hdl_done,
    input  logic             chain_req,
    input  logic [NUM_W-1:0] chain_num,
    input  logic             rest_valid,
    input  logic [NUM_W-1:0] rest_num_in,
    output seq_state_e       state,
    output logic [CNT_W-1:0] cnt,
    output logic [NUM_W-1:0] pend_num,
    output logic [NUM_W-1:0] cur_num,
    output logic             take_ack,
    output logic             push_en,
    output logic             pop_en,
    output logic             vec_rd,
    output logic             vec_cap,
    output logic             sp_dec,
    output logic             sp_inc,
    output logic             hdl_start,
    output logic             exc_ret,
    output logic             busy
);

    localparam int VEC_LEN     = ENTRY_CYCLES - FRAME_WORDS - 1;
    localparam int TCHAIN_LEN  = CHAIN_CYCLES - VEC_LEN - 1;
    localparam int RESTORE_LEN = ENTRY_CYCLES - FRAME_WORDS - 1;
    localparam logic [CNT_W-1:0] FRAME_LAST   = CNT_W'(FRAME_WORDS - 1);
    localparam logic [CNT_W-1:0] VEC_LAST     = CNT_W'(VEC_LEN - 1);
    localparam logic [CNT_W-1:0] TCHAIN_LAST  = CNT_W'(TCHAIN_LEN - 1);
    localparam logic [CNT_W-1:0] RESTORE_LAST = CNT_W'(RESTORE_LEN - 1);

    seq_state_e       st_nx;
    logic [CNT_W-1:0] cnt_nx;
    logic [NUM_W-1:0] pend_nx;
    logic [NUM_W-1:0] cur_nx;
    logic [NUM_W-1:0] rest_num;
    logic [NUM_W-1:0] rest_nx;

    // Next-state decision
    always_comb begin
        st_nx   = state;
        cnt_nx  = cnt + 1'b1;
        pend_nx = pend_num;
        cur_nx  = cur_num;
        rest_nx = rest_valid ? rest_num_in : rest_num;
        unique case (state)
            ST_IDLE: begin
                cnt_nx = '0;
                if (take_req) begin
                    st_nx   = ST_STACK;
                    pend_nx = take_num;
                end
            end
            ST_STACK: begin
                if (cnt == FRAME_LAST) begin
                    st_nx  = ST_VEC;
                    cnt_nx = '0;
                end
            end
            ST_VEC: begin
                if (cnt == VEC_LAST) begin
                    st_nx  = ST_START;
                    cnt_nx = '0;
                    cur_nx = pend_num;
                end
            end
            ST_START: begin
                st_nx  = ST_ACTIVE;
                cnt_nx = '0;
            end
            ST_ACTIVE: begin
                cnt_nx = '0;
                if (hdl_done) begin
                    if (chain_req) begin
                        st_nx   = ST_TCHAIN;
                        pend_nx = chain_num;
                    end else begin
                        st_nx = ST_UNSTACK;
                    end
                end else if (take_req) begin
                    st_nx   = ST_STACK;
                    pend_nx = take_num;
                end
            end
            ST_TCHAIN: begin
                if (cnt == TCHAIN_LAST) begin
                    st_nx  = ST_VEC;
                    cnt_nx = '0;
                end
            end
            ST_UNSTACK: begin
                if (cnt == FRAME_LAST) begin
                    st_nx  = ST_RESTORE;
                    cnt_nx = '0;
                end
            end
            ST_RESTORE: begin
                if (cnt == RESTORE_LAST) begin
                    st_nx  = ST_RET;
                    cnt_nx = '0;
                    cur_nx = rest_num;
                end
            end
            ST_RET: begin
                cnt_nx = '0;
                st_nx  = (cur_num == '0) ? ST_IDLE : ST_ACTIVE;
            end
            default: begin
                st_nx  = ST_IDLE;
                cnt_nx = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            pend_num <= '0;
            cur_num  <= '0;
            rest_num <= '0;
        end else begin
            state    <= st_nx;
            cnt      <= cnt_nx;
            pend_num <= pend_nx;
            cur_num  <= cur_nx;
            rest_num <= rest_nx;
        end
    end

    // Outputs
    always_comb begin
        take_ack  = take_req && ((state == ST_IDLE) || ((state == ST_ACTIVE) && !hdl_done));
        push_en   = (state == ST_STACK);
        pop_en    = (state == ST_UNSTACK);
        vec_rd    = (state == ST_VEC) && (cnt == '0);
        vec_cap   = (state == ST_VEC) && (cnt == CNT_W'(1));
        sp_dec    = (state == ST_STACK) && (cnt == FRAME_LAST);
        sp_inc    = (state == ST_RESTORE) && (cnt == RESTORE_LAST);
        hdl_start = (state == ST_START);
        exc_ret   = (state == ST_RET);
        busy      = !((state == ST_IDLE) || (state == ST_ACTIVE) || (state == ST_START));
    end

    // R2: a handler start always follows the vector read
    a_r2_start_after_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START) |-> ($past(state) == ST_VEC));

    // R11: the running number only moves on a start or a return
    a_r11_num_moves_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_num != $past(cur_num)) |-> ((state == ST_START) || (state == ST_RET)));

endmodule

// File: rtl/exc_seq_frame.sv
module exc_seq_frame
    import exc_seq_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          NUM_W    = 6,
    parameter int          IDX_W    = 3,
    parameter logic [31:0] SP_RESET = 32'h0000_1000
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [IDX_W-1:0]                idx,
    input  logic                            push_en,
    input  logic                            pop_en,
    input  logic                            sp_dec,
    input  logic                            sp_inc,
    input  logic [(FRAME_WORDS-1)*XLEN-1:0] core_regs,
    input  logic [XLEN-NUM_W-1:0]           core_flags,
    input  logic [NUM_W-1:0]                cur_num,
    input  logic [XLEN-1:0]                 mem_rdata,
    output logic [XLEN-1:0]                 sp,
    output logic [XLEN-1:0]                 frame_addr,
    output logic [XLEN-1:0]                 frame_wdata,
    output logic                            ctx_wr_en,
    output logic [IDX_W-1:0]                ctx_wr_idx,
    output logic [XLEN-1:0]                 ctx_wr_data,
    output logic                            rest_valid,
    output logic [NUM_W-1:0]                rest_num
);

    localparam logic [XLEN-1:0]  FRAME_BYTES = XLEN'(FRAME_WORDS * WORD_BYTES);
    localparam logic [IDX_W-1:0] STATUS_IDX  = IDX_W'(FRAME_WORDS - 1);

    logic [XLEN-1:0]  words [FRAME_WORDS];
    logic [XLEN-1:0]  offs;
    logic             rd_q;
    logic [IDX_W-1:0] idx_q;

    genvar g;
    generate
        for (g = 0; g < FRAME_WORDS - 1; g++) begin : g_regs
            assign words[g] = core_regs[g*XLEN +: XLEN];
        end
    endgenerate
    assign words[FRAME_WORDS-1] = {core_flags, cur_num};

    assign offs        = XLEN'({idx, 2'b00});
    assign frame_wdata = words[idx];
    assign frame_addr  = push_en ? (sp - FRAME_BYTES + offs) : (sp + offs);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp    <= SP_RESET;
            rd_q  <= 1'b0;
            idx_q <= '0;
        end else begin
            rd_q  <= pop_en;
            idx_q <= idx;
            if (sp_dec)
                sp <= sp - FRAME_BYTES;
            else if (sp_inc)
                sp <= sp + FRAME_BYTES;
        end
    end

    assign ctx_wr_en   = rd_q;
    assign ctx_wr_idx  = idx_q;
    assign ctx_wr_data = mem_rdata;
    assign rest_valid  = rd_q && (idx_q == STATUS_IDX);
    assign rest_num    = mem_rdata[NUM_W-1:0];

    // R4: stack pointer stays word-aligned
    a_r4_sp_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        sp[1:0] == 2'b00);

    // R4: entry lowers the stack pointer by one frame
    a_r4_sp_drop: assert property (@(posedge clk) disable iff (!rst_n)
        sp_dec |=> (sp == $past(sp) - FRAME_BYTES));

    // R7: final return raises the stack pointer by one frame
    a_r7_sp_rise: assert property (@(posedge clk) disable iff (!rst_n)
        sp_inc |=> (sp == $past(sp) + FRAME_BYTES));

endmodule

// File: rtl/exc_seq_vec.sv
module exc_seq_vec #(
    parameter int XLEN  = 32,
    parameter int NUM_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [XLEN-1:0]  vtor,
    input  logic [NUM_W-1:0] pend_num,
    input  logic             vec_rd,
    input  logic             vec_cap,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic [XLEN-1:0]  vec_addr,
    output logic [XLEN-1:0]  hdl_addr
);

    assign vec_addr = vtor + (XLEN'(pend_num) << 2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hdl_addr <= '0;
        else if (vec_cap)
            hdl_addr <= mem_rdata;
    end

    // R5: the handler address is captured the cycle after the table read
    a_r5_capture_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        vec_cap |-> $past(vec_rd));

endmodule

// File: rtl/exc_seq_top.sv
module exc_seq_top
    import exc_seq_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          NUM_W    = 6,
    parameter logic [31:0] SP_RESET = 32'h0000_1000
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            take_req,
    input  logic [NUM_W-1:0]                take_num,
    output logic                            take_ack,
    input  logic                            hdl_done,
    input  logic                            chain_req,
    input  logic [NUM_W-1:0]                chain_num,
    input  logic [XLEN-1:0]                 vtor,
    input  logic [(FRAME_WORDS-1)*XLEN-1:0] core_regs,
    input  logic [XLEN-NUM_W-1:0]           core_flags,
    output logic                            mem_we,
    output logic                            mem_re,
    output logic [XLEN-1:0]                 mem_addr,
    output logic [XLEN-1:0]                 mem_wdata,
    input  logic [XLEN-1:0]                 mem_rdata,
    output logic                            hdl_start,
    output logic [XLEN-1:0]                 hdl_addr,
    output logic                            exc_ret,
    output logic                            busy,
    output logic [NUM_W-1:0]                cur_num,
    output logic [XLEN-1:0]                 sp,
    output logic                            ctx_wr_en,
    output logic [$clog2(FRAME_WORDS)-1:0]  ctx_wr_idx,
    output logic [XLEN-1:0]                 ctx_wr_data
);

    localparam int IDX_W = $clog2(FRAME_WORDS);
    localparam int CNT_W = $clog2(FRAME_WORDS + 1);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [NUM_W-1:0] pend_num;
    logic             push_en, pop_en, vec_rd, vec_cap, sp_dec, sp_inc;
    logic             rest_valid;
    logic [NUM_W-1:0] rest_num;
    logic [XLEN-1:0]  frame_addr, frame_wdata, vec_addr;

    exc_seq_ctrl #(.NUM_W(NUM_W), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_req   (take_req),
        .take_num   (take_num),
        .hdl_done   (hdl_done),
        .chain_req  (chain_req),
        .chain_num  (chain_num),
        .rest_valid (rest_valid),
        .rest_num_in(rest_num),
        .state      (state),
        .cnt        (cnt),
        .pend_num   (pend_num),
        .cur_num    (cur_num),
        .take_ack   (take_ack),
        .push_en    (push_en),
        .pop_en     (pop_en),
        .vec_rd     (vec_rd),
        .vec_cap    (vec_cap),
        .sp_dec     (sp_dec),
        .sp_inc     (sp_inc),
        .hdl_start  (hdl_start),
        .exc_ret    (exc_ret),
        .busy       (busy)
    );

    exc_seq_frame #(.XLEN(XLEN), .NUM_W(NUM_W), .IDX_W(IDX_W), .SP_RESET(SP_RESET)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (cnt[IDX_W-1:0]),
        .push_en    (push_en),
        .pop_en     (pop_en),
        .sp_dec     (sp_dec),
        .sp_inc     (sp_inc),
        .core_regs  (core_regs),
        .core_flags (core_flags),
        .cur_num    (cur_num),
        .mem_rdata  (mem_rdata),
        .sp         (sp),
        .frame_addr (frame_addr),
        .frame_wdata(frame_wdata),
        .ctx_wr_en  (ctx_wr_en),
        .ctx_wr_idx (ctx_wr_idx),
        .ctx_wr_data(ctx_wr_data),
        .rest_valid (rest_valid),
        .rest_num   (rest_num)
    );

    exc_seq_vec #(.XLEN(XLEN), .NUM_W(NUM_W)) u_vec (
        .clk      (clk),
        .rst_n    (rst_n),
        .vtor     (vtor),
        .pend_num (pend_num),
        .vec_rd   (vec_rd),
        .vec_cap  (vec_cap),
        .mem_rdata(mem_rdata),
        .vec_addr (vec_addr),
        .hdl_addr (hdl_addr)
    );

    assign mem_we    = push_en;
    assign mem_re    = pop_en | vec_rd;
    assign mem_addr  = (state == ST_VEC) ? vec_addr : frame_addr;
    assign mem_wdata = frame_wdata;

    // R10: nothing is accepted while sequencing
    a_r10_no_ack_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !take_ack);

    // R3: writes and reads never share a cycle
    a_r3_write_excludes_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !mem_re);

    // R6: the tail-chain lead-in leaves the stack pointer alone
    a_r6_chain_keeps_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TCHAIN) |=> $stable(sp));

endmodule

// File: tb/sim_exc_seq_top.sv
module sim_exc_seq_top;

    localparam int          XLEN  = 32;
    localparam int          NUM_W = 6;
    localparam logic [31:0] SP0   = 32'h0000_1000;
    localparam int          MEMW  = 1024;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               take_req = 1'b0;
    logic [NUM_W-1:0]   take_num = '0;
    logic               take_ack;
    logic               hdl_done = 1'b0;
    logic               chain_req = 1'b0;
    logic [NUM_W-1:0]   chain_num = '0;
    logic [XLEN-1:0]    vtor = 32'h100;
    logic [7*XLEN-1:0]  core_regs = '0;
    logic [XLEN-NUM_W-1:0] core_flags = '0;
    logic               mem_we, mem_re;
    logic [XLEN-1:0]    mem_addr, mem_wdata;
    logic [XLEN-1:0]    mem_rdata = '0;
    logic               hdl_start, exc_ret, busy, ctx_wr_en;
    logic [XLEN-1:0]    hdl_addr, sp, ctx_wr_data;
    logic [NUM_W-1:0]   cur_num;
    logic [2:0]         ctx_wr_idx;

    logic [31:0] mem [MEMW];
    logic [31:0] ctx_got [8];
    int wr_cnt = 0, re_cnt = 0, ctx_cnt = 0;
    int nchk = 0, nerr = 0;
    int nest [16];
    int depth = 0;
    int exp_cur = 0;
    logic [31:0] sp_exp = SP0;

    exc_seq_top #(.XLEN(XLEN), .NUM_W(NUM_W), .SP_RESET(SP0)) u0 (
        .clk(clk), .rst_n(rst_n), .take_req(take_req), .take_num(take_num), .take_ack(take_ack),
        .hdl_done(hdl_done), .chain_req(chain_req), .chain_num(chain_num), .vtor(vtor),
        .core_regs(core_regs), .core_flags(core_flags), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .hdl_start(hdl_start),
        .hdl_addr(hdl_addr), .exc_ret(exc_ret), .busy(busy), .cur_num(cur_num), .sp(sp),
        .ctx_wr_en(ctx_wr_en), .ctx_wr_idx(ctx_wr_idx), .ctx_wr_data(ctx_wr_data)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] vec_val(input int idx);
        return 32'h4000_0000 + 32'(idx) * 32'd16;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEMW; i++) mem[i] <= vec_val(i);
        end else begin
            if (mem_we) begin
                mem[mem_addr[11:2]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (mem_re) begin
                mem_rdata <= mem[mem_addr[11:2]];
                re_cnt <= re_cnt + 1;
            end
            if (ctx_wr_en) begin
                ctx_got[ctx_wr_idx] <= ctx_wr_data;
                ctx_cnt <= ctx_cnt + 1;
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic set_ctx(input int tag);
        for (int i = 0; i < 7; i++)
            core_regs[i*32 +: 32] = (32'(tag) << 24) | (32'(i) << 16) | 32'h5A5A;
        core_flags = 26'h15A_C3F0 ^ 26'(tag);
    endtask

    // Entry from thread or by preemption (R2 R3 R4 R5 R9 R11)
    task automatic enter(input int num, input logic [31:0] vt);
        int n;
        int w0;
        int base;
        int prev;
        logic [25:0] fl;
        @(negedge clk);
        vtor = vt;
        set_ctx(num);
        fl = core_flags;
        take_req = 1'b1;
        take_num = NUM_W'(num);
        #1;
        chk("R2 take_ack on request", {31'b0, take_ack}, 32'd1);
        w0 = wr_cnt;
        prev = exp_cur;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) take_req = 1'b0;
            if (n == 5) chk("R2 busy during entry", {31'b0, busy}, 32'd1);
            if (n == 11) chk("R11 number unchanged before start", {26'b0, cur_num}, 32'(prev));
        end while (!hdl_start && n < 40);
        chk("R2 entry latency", 32'(n), 32'd12);
        chk("R5 handler address", hdl_addr, vec_val(int'(vt >> 2) + num));
        sp_exp = sp_exp - 32;
        chk("R4 sp after entry", sp, sp_exp);
        chk("R3 frame writes", 32'(wr_cnt - w0), 32'd8);
        base = int'(sp_exp >> 2);
        chk("R3 status word", mem[base+7], {fl, 6'(prev)});
        chk("R3 frame word 0", mem[base], (32'(num) << 24) | 32'h5A5A);
        chk("R3 frame word 6", mem[base+6], (32'(num) << 24) | (32'd6 << 16) | 32'h5A5A);
        chk("R11 number at start", {26'b0, cur_num}, 32'(num));
        nest[depth] = prev;
        depth++;
        exp_cur = num;
    endtask

    // Plain completion with unstacking (R7 R8)
    task automatic leave();
        int n;
        int c0;
        int base;
        base = int'(sp_exp >> 2);
        @(negedge clk);
        hdl_done = 1'b1;
        chain_req = 1'b0;
        c0 = ctx_cnt;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) hdl_done = 1'b0;
        end while (!exc_ret && n < 40);
        depth--;
        exp_cur = nest[depth];
        chk("R7 return latency", 32'(n), 32'd12);
        sp_exp = sp_exp + 32;
        chk("R7 sp after return", sp, sp_exp);
        chk("R7 restored word count", 32'(ctx_cnt - c0), 32'd8);
        for (int i = 0; i < 8; i++)
            chk("R7 restored word", ctx_got[i], mem[base+i]);
        chk("R8 number after return", {26'b0, cur_num}, 32'(exp_cur));
        @(negedge clk);
        chk("R8 not busy after return", {31'b0, busy}, 32'd0);
        chk("R8 no new start on resume", {31'b0, hdl_start}, 32'd0);
    endtask

    // Completion with tail-chain (R6)
    task automatic chain_to(input int num, input logic [31:0] vt);
        int n;
        int w0;
        @(negedge clk);
        vtor = vt;
        hdl_done = 1'b1;
        chain_req = 1'b1;
        chain_num = NUM_W'(num);
        w0 = wr_cnt;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                hdl_done = 1'b0;
                chain_req = 1'b0;
            end
        end while (!hdl_start && n < 40);
        chk("R6 chain latency", 32'(n), 32'd6);
        chk("R6 no writes on chain", 32'(wr_cnt - w0), 32'd0);
        chk("R6 sp unchanged on chain", sp, sp_exp);
        chk("R5 chained handler address", hdl_addr, vec_val(int'(vt >> 2) + num));
        chk("R11 number after chain", {26'b0, cur_num}, 32'(num));
        exp_cur = num;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 hdl_start", {31'b0, hdl_start}, 32'd0);
        chk("R1 exc_ret", {31'b0, exc_ret}, 32'd0);
        chk("R1 mem strobes", {30'b0, mem_we, mem_re}, 32'd0);
        chk("R1 cur_num", {26'b0, cur_num}, 32'd0);
        chk("R1 sp", sp, SP0);

        // Sweep of entry and return from thread over two table bases
        for (int v = 0; v < 2; v++) begin
            for (int num = 1; num < 16; num++) begin
                enter(num, (v == 0) ? 32'h100 : 32'h600);
                leave();
            end
        end

        // R8: completion in thread code has no effect
        begin
            int r0;
            r0 = re_cnt;
            @(negedge clk);
            hdl_done = 1'b1;
            @(negedge clk);
            hdl_done = 1'b0;
            repeat (15) @(negedge clk);
            chk("R8 done ignored in thread: reads", 32'(re_cnt - r0), 32'd0);
            chk("R8 done ignored in thread: sp", sp, SP0);
            chk("R8 done ignored in thread: busy", {31'b0, busy}, 32'd0);
        end

        // Tail-chain sweep
        enter(1, 32'h100);
        for (int num = 2; num < 16; num++)
            chain_to(num, (num % 2 == 0) ? 32'h600 : 32'h100);
        leave();

        // R9 nested preemption with chain inside
        enter(5, 32'h100);
        enter(9, 32'h100);
        enter(12, 32'h600);
        leave();
        chain_to(14, 32'h100);
        leave();
        leave();

        // R10 deferral of a request during sequencing
        begin
            int n;
            @(negedge clk);
            vtor = 32'h100;
            set_ctx(3);
            take_req = 1'b1;
            take_num = 6'd3;
            #1;
            chk("R10 first request accepted", {31'b0, take_ack}, 32'd1);
            @(negedge clk);
            take_num = 6'd9;
            #1;
            chk("R10 no ack while busy", {31'b0, take_ack}, 32'd0);
            n = 1;
            while (!hdl_start && n < 40) begin
                @(negedge clk);
                n++;
            end
            #1;
            chk("R10 entry latency with held request", 32'(n), 32'd12);
            chk("R10 no ack in start cycle", {31'b0, take_ack}, 32'd0);
            nest[depth] = 0;
            depth++;
            exp_cur = 3;
            sp_exp = sp_exp - 32;
            @(negedge clk);
            set_ctx(9);
            #1;
            chk("R10 held request taken once handler runs", {31'b0, take_ack}, 32'd1);
            n = 0;
            do begin
                @(negedge clk);
                n++;
                if (n == 1) take_req = 1'b0;
            end while (!hdl_start && n < 40);
            chk("R9 preemption latency", 32'(n), 32'd12);
            sp_exp = sp_exp - 32;
            chk("R9 sp after preemption", sp, sp_exp);
            chk("R9 status holds interrupted number", mem[int'(sp_exp >> 2) + 7], {26'h15A_C3F0 ^ 26'd9, 6'd3});
            nest[depth] = 3;
            depth++;
            exp_cur = 9;
            leave();
            leave();
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule